// File: doc/BRIEF.md
# ADC Power-Mode Conversion Sequencer

This controller sits beside a sampling converter core and decides, cycle by cycle, whether the core circuitry and its reference are powered, when a conversion runs and when the core shuts down again. A single trigger input carries two meanings. Its falling edge wakes a powered-down core and its rising edge starts a conversion. A conversion is modelled as a fixed number of cycles during which `busy` is high. The power policy comes from a 2-bit mode field loaded through a one-cycle write strobe.

After reset the block waits in a power-on state. The first falling trigger edge then starts a timeout followed by a self-calibration, and `busy` stays high for both. Any mode write made before that edge cancels the phase and the block goes straight to normal service. All durations are cycle-count parameters: the wake settling time, the conversion time, the timeout and the calibration.

Top module: `pwr_conv_seq`

## Requirements
- R1: During and straight after synchronous reset, `core_pwr_en` and `ref_pwr_en` are 1, and `busy` and `short_pulse_err` are 0. The mode is normal (00).
- R2: Mode encoding on `cfg_mode`: 00 keeps the core powered. 01 fully powers down (core and reference off) when `busy` falls after a conversion. 11 partially powers down (core off, reference on) when `busy` falls. 10 keeps the core fully powered down at all times.
- R3: With no prior write, the first falling edge of `conv_trig` after reset holds `busy` high for TMO_CYC+CAL_CYC cycles, beginning the cycle after that edge. Trigger edges during this time have no effect.
- R4: A write on `cfg_we` before the first falling trigger edge cancels the timeout and calibration. The next rising edge then starts an ordinary conversion of CONV_CYC cycles.
- R5: While the core is powered and idle, a rising edge of `conv_trig` raises `busy` in the next cycle for exactly CONV_CYC cycles. The core is never powered down while `busy` is high.
- R6: In modes 01 and 11 the power-down takes effect in the same cycle that `busy` falls. The reference stays enabled only in mode 11.
- R7: In modes 01 and 11, a falling trigger edge while powered down re-enables core and reference from the next cycle and starts a WAKE_CYC-cycle settling interval. If the trigger has been low for at least WAKE_CYC cycles, its rising edge starts the conversion at once, with no error.
- R8: A rising edge that arrives before settling completes sets `short_pulse_err`, which stays set until reset. The conversion then starts when settling completes, WAKE_CYC cycles after the falling edge.
- R9: In mode 10 the core and reference stay off and `busy` stays low, whatever the trigger does.
- R10: Trigger edges that arrive while a conversion is running neither lengthen it nor start another one.
- R11: A mode written while `busy` is high takes effect only when `busy` falls. A write made in that very cycle decides the power state entered.
- R12: Writing mode 00 while powered down re-powers the core through the settling interval, after which a rising edge converts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | One-cycle strobe that writes the mode field |
| cfg_mode | input | 2 | Power-management mode value written on `cfg_we` |
| conv_trig | input | 1 | Trigger; idles high. Falling edge wakes, rising edge converts |
| busy | output | 1 | High during calibration phase and during conversions |
| core_pwr_en | output | 1 | Enable for the core circuitry |
| ref_pwr_en | output | 1 | Enable for the reference |
| short_pulse_err | output | 1 | Sticky flag: trigger pulse shorter than the settling interval |

## Verification
Two events can land in the same cycle here. The trigger's rising edge can coincide with expiry of the wake settling timer, and a mode write can coincide with the last cycle of a conversion. The bench sweeps the trigger low-time from one cycle to two past WAKE_CYC in both power-down-after modes. For each width it computes whether the error flag must be set and how many cycles must pass before `busy` rises, so the width equal to WAKE_CYC must convert at once without error. A second case times a mode write onto the final busy cycle and judges the power enables seen in the next cycle against the newly written mode.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL      = 2'b00,
        PM_FULL_AFTER  = 2'b01,
        PM_FULL_ALWAYS = 2'b10,
        PM_PART_AFTER  = 2'b11
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_POR,
        ST_TMO,
        ST_CAL,
        ST_IDLE,
        ST_CONV,
        ST_DOWN,
        ST_WAKE
    } seq_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } trig_edge_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // State entered once a powered phase (calibration, power-on) ends.
    function automatic seq_state_e rest_state(input pm_mode_e m);
        return (m == PM_FULL_ALWAYS) ? ST_DOWN : ST_IDLE;
    endfunction

    // State entered when a conversion ends.
    function automatic seq_state_e post_conv_state(input pm_mode_e m);
        return (m == PM_NORMAL) ? ST_IDLE : ST_DOWN;
    endfunction

    function automatic logic keeps_ref(input pm_mode_e m);
        return m == PM_PART_AFTER;
    endfunction

endpackage

// File: rtl/pwr_seq_edge.sv
module pwr_seq_edge
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    output trig_edge_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= lvl;
    end

    always_comb begin
        ev.fall = prev & ~lvl;
        ev.rise = ~prev & lvl;
    end

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == TW'(1));

    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pwr_seq_mode.sv
module pwr_seq_mode
    import pwr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [1:0] wdata,
    input  logic     busy,
    input  logic     commit,
    output pm_mode_e act,
    output pm_mode_e nxt
);
    pm_mode_e pend;
    logic     pend_v;

    always_comb begin
        if (busy && !commit) nxt = act;
        else if (we)         nxt = pm_mode_e'(wdata);
        else if (pend_v)     nxt = pend;
        else                 nxt = act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= PM_NORMAL;
            pend   <= PM_NORMAL;
            pend_v <= 1'b0;
        end else if (!busy || commit) begin
            act    <= nxt;
            pend_v <= 1'b0;
        end else if (we) begin
            pend   <= pm_mode_e'(wdata);
            pend_v <= 1'b1;
        end
    end

    // R11: the live mode does not move while busy, except at the commit cycle
    a_r11_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit) |=> (act == $past(act)));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int TW       = 8,
    parameter int WAKE_CYC = 4,
    parameter int CONV_CYC = 6,
    parameter int TMO_CYC  = 5,
    parameter int CAL_CYC  = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  trig_edge_t    ev,
    input  logic          cfg_we,
    input  pm_mode_e      act_mode,
    input  pm_mode_e      nxt_mode,
    input  logic          tmr_exp,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          busy,
    output logic          commit,
    output logic          core_en,
    output logic          ref_en,
    output logic          short_err
);
    seq_state_e st, st_n;
    logic       start_pend;
    logic       err_set;

    always_comb begin
        st_n     = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        commit   = 1'b0;
        err_set  = 1'b0;
        unique case (st)
            ST_POR: begin
                if (cfg_we) begin
                    st_n = rest_state(nxt_mode);
                end else if (ev.fall) begin
                    st_n     = ST_TMO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TMO_CYC);
                end
            end
            ST_TMO: begin
                if (tmr_exp) begin
                    st_n     = ST_CAL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CAL_CYC);
                end
            end
            ST_CAL: begin
                if (tmr_exp) begin
                    commit = 1'b1;
                    st_n   = rest_state(nxt_mode);
                end
            end
            ST_IDLE: begin
                if (nxt_mode == PM_FULL_ALWAYS) begin
                    st_n = ST_DOWN;
                end else if (ev.rise) begin
                    st_n     = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CONV_CYC);
                end
            end
            ST_CONV: begin
                if (tmr_exp) begin
                    commit = 1'b1;
                    st_n   = post_conv_state(nxt_mode);
                end
            end
            ST_DOWN: begin
                if (nxt_mode == PM_NORMAL ||
                    (nxt_mode != PM_FULL_ALWAYS && ev.fall)) begin
                    st_n     = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WAKE_CYC);
                end
            end
            ST_WAKE: begin
                if (tmr_exp) begin
                    if (start_pend || ev.rise) begin
                        st_n     = ST_CONV;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(CONV_CYC);
                    end else begin
                        st_n = rest_state(nxt_mode);
                    end
                end else if (ev.rise) begin
                    err_set = 1'b1;
                end
            end
            default: st_n = ST_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_POR;
            start_pend <= 1'b0;
            short_err  <= 1'b0;
        end else begin
            st <= st_n;
            if (st != ST_WAKE || tmr_exp) start_pend <= 1'b0;
            else if (err_set)            start_pend <= 1'b1;
            if (err_set) short_err <= 1'b1;
        end
    end

    assign busy    = (st == ST_TMO) || (st == ST_CAL) || (st == ST_CONV);
    assign core_en = (st != ST_DOWN);
    assign ref_en  = (st != ST_DOWN) || keeps_ref(act_mode);

    // R8: the short-pulse flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        short_err |=> short_err);

    // R9: always-off mode never leaves the powered-down state
    a_r9_stay_down: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DOWN && nxt_mode == PM_FULL_ALWAYS) |=> (st == ST_DOWN));

    // R10: a conversion runs until its timer expires, whatever the trigger does
    a_r10_conv_runs: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CONV && !tmr_exp) |=> (st == ST_CONV));

    // R3: calibration phase is entered only from the timeout phase
    a_r3_cal_after_tmo: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_CAL) |-> ($past(st) == ST_TMO));

endmodule

// File: rtl/pwr_conv_seq.sv
module pwr_conv_seq
    import pwr_seq_pkg::*;
#(
    parameter int WAKE_CYC = 250,
    parameter int CONV_CYC = 100,
    parameter int TMO_CYC  = 2000000,
    parameter int CAL_CYC  = 1500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic       conv_trig,
    output logic       busy,
    output logic       core_pwr_en,
    output logic       ref_pwr_en,
    output logic       short_pulse_err
);
    localparam int MAXC = max_of4(WAKE_CYC, CONV_CYC, TMO_CYC, CAL_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    trig_edge_t    ev;
    pm_mode_e      act_mode, nxt_mode;
    logic          tmr_load, tmr_exp, commit;
    logic [TW-1:0] tmr_val;

    pwr_seq_edge u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (conv_trig),
        .ev  (ev)
    );

    pwr_seq_mode u_mode (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_mode),
        .busy   (busy),
        .commit (commit),
        .act    (act_mode),
        .nxt    (nxt_mode)
    );

    pwr_seq_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    pwr_seq_fsm #(
        .TW       (TW),
        .WAKE_CYC (WAKE_CYC),
        .CONV_CYC (CONV_CYC),
        .TMO_CYC  (TMO_CYC),
        .CAL_CYC  (CAL_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cfg_we    (cfg_we),
        .act_mode  (act_mode),
        .nxt_mode  (nxt_mode),
        .tmr_exp   (tmr_exp),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .busy      (busy),
        .commit    (commit),
        .core_en   (core_pwr_en),
        .ref_en    (ref_pwr_en),
        .short_err (short_pulse_err)
    );

    // R5: a busy core is always powered
    a_r5_busy_powered: assert property (@(posedge clk) disable iff (rst)
        busy |-> core_pwr_en);

    // R6: reference alone stays on only in partial mode
    a_r6_ref_partial_only: assert property (@(posedge clk) disable iff (rst)
        (!core_pwr_en && ref_pwr_en) |-> (act_mode == PM_PART_AFTER));

    // R7: leaving power-down without busy means settling has begun
    a_r7_wake_not_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(core_pwr_en) |-> !busy);

endmodule

// File: tb/pwr_conv_seq_bench.sv
module pwr_conv_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int C  = 6;
    localparam int T  = 5;
    localparam int K  = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       conv_trig = 1'b1;
    logic       busy, core_pwr_en, ref_pwr_en, short_pulse_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_conv_seq #(.WAKE_CYC(W), .CONV_CYC(C), .TMO_CYC(T), .CAL_CYC(K)) u_pwr_conv_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .conv_trig(conv_trig), .busy(busy), .core_pwr_en(core_pwr_en),
        .ref_pwr_en(ref_pwr_en), .short_pulse_err(short_pulse_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_we = 1'b0; conv_trig = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
    endtask

    task automatic write_mode(input logic [1:0] m);
        cfg_we = 1'b1; cfg_mode = m;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse();
        conv_trig = 1'b0;
        step();
        conv_trig = 1'b1;
        step();
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            step();
        end
    endtask

    initial begin
        int n;
        int lat;
        do_reset();
        // R1 reset state
        chk("R1 core_en", core_pwr_en, 1);
        chk("R1 ref_en", ref_pwr_en, 1);
        chk("R1 busy", busy, 0);
        chk("R1 err", short_pulse_err, 0);

        // R3 power-on timeout plus calibration
        pulse();
        count_busy(n);
        chk("R3 cal busy length", n, T + K - 1);
        chk("R3 powered after cal", core_pwr_en, 1);
        pulse();
        count_busy(n);
        chk("R3 conversion after cal", n, C);

        // R4 write cancels calibration
        do_reset();
        write_mode(2'b00);
        pulse();
        count_busy(n);
        chk("R4 no cal, plain conversion", n, C);

        // R2/R5/R6 conversion in each after-mode
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            do_reset();
            write_mode(2'(m));
            pulse();
            count_busy(n);
            chk("R5 conversion length", n, C);
            chk("R6 core after conv", core_pwr_en, (m == 0) ? 1 : 0);
            chk("R2 ref after conv", ref_pwr_en, (m == 1) ? 0 : 1);
        end

        // R7/R8 wake sweep over trigger low widths
        for (int m = 1; m < 4; m += 2) begin
            for (int w = 1; w <= W + 2; w++) begin
                do_reset();
                write_mode(2'(m));
                pulse();
                count_busy(n);
                chk("R6 powered down", core_pwr_en, 0);
                conv_trig = 1'b0;
                for (int i = 0; i < w; i++) begin
                    step();
                    if (i == 0) begin
                        chk("R7 wake core_en", core_pwr_en, 1);
                        chk("R7 wake ref_en", ref_pwr_en, 1);
                    end
                end
                conv_trig = 1'b1;
                step();
                chk("R8 short flag", short_pulse_err, (w < W) ? 1 : 0);
                lat = 0;
                while (!busy && lat < 50) begin
                    lat++;
                    step();
                end
                chk("R7 start latency", lat, (w < W) ? (W - w) : 0);
                count_busy(n);
                chk("R7 conv length after wake", n, C);
                chk("R6 down again", core_pwr_en, 0);
            end
        end

        // R9 always-off mode
        do_reset();
        write_mode(2'b10);
        chk("R9 core off", core_pwr_en, 0);
        chk("R9 ref off", ref_pwr_en, 0);
        pulse();
        n = 0;
        for (int i = 0; i < W + C + 2; i++) begin
            if (core_pwr_en || ref_pwr_en || busy) n++;
            step();
        end
        chk("R9 stays off under trigger", n, 0);

        // R12 leave always-off by writing normal
        write_mode(2'b00);
        chk("R12 core re-powered", core_pwr_en, 1);
        repeat (W) step();
        chk("R12 idle after settle", busy, 0);
        pulse();
        count_busy(n);
        chk("R12 conversion", n, C);

        // R10 edges during a conversion are ignored
        do_reset();
        write_mode(2'b00);
        pulse();
        n = 0;
        for (int i = 0; i < C; i++) begin
            if (busy) n++;
            if (i == 1) conv_trig = 1'b0;
            if (i == 2) conv_trig = 1'b1;
            step();
        end
        chk("R10 busy through conversion", n, C);
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy) n++;
            step();
        end
        chk("R10 no second conversion", n, 0);

        // R11 write during busy deferred
        pulse();
        for (int i = 0; i < C; i++) begin
            if (i == 2) cfg_we = 1'b1;
            cfg_mode = 2'b01;
            if (i == 3) begin
                cfg_we = 1'b0;
                chk("R11 still powered mid-conv", core_pwr_en, 1);
            end
            step();
        end
        chk("R11 busy ended", busy, 0);
        chk("R11 deferred full down core", core_pwr_en, 0);
        chk("R11 deferred full down ref", ref_pwr_en, 0);

        // R11 write on the last busy cycle
        do_reset();
        write_mode(2'b00);
        pulse();
        for (int i = 0; i < C; i++) begin
            if (i == C - 1) begin
                cfg_we = 1'b1;
                cfg_mode = 2'b11;
            end
            step();
        end
        cfg_we = 1'b0;
        chk("R11 coincident busy", busy, 0);
        chk("R11 coincident core", core_pwr_en, 0);
        chk("R11 coincident ref", ref_pwr_en, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule